// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs from one input clock. Software programs each channel through a small word-addressed register bus: a control word that carries a run bit and a 14-bit clock divider, a high-time count and a cycle-length count. Every channel has its own divider, so one count tick of that channel lasts (divider + 1) input clocks and both the high time and the cycle length scale by that factor.

A global run bit sits above the four channel run bits; a channel produces pulses only while both are set. All registers read back exactly as written (unused bits read zero), so software can flip a run bit with a read-modify-write without disturbing the divider. Changes to the counts or the divider made while a channel is running are held back until the current cycle ends, which avoids runt pulses.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Channel n's words sit at byte address n*16 + 0x0 (control), + 0x4 (high count), + 0x8 (cycle count); the global word is at 0x3C; address bits 1:0 are ignored and read data is valid combinationally in the same cycle as the address.
- R3: In the control word bit 0 is the channel run bit and bits 15:2 the divider; all other bits read as zero, and both fields read back as written.
- R4: Offset 0xC within channels 0 to 2 (bytes 0x0C, 0x1C, 0x2C) reads zero, and writes there change no register.
- R5: One output cycle lasts (divider + 1) * cycle_count input clocks; a cycle count of zero behaves as one.
- R6: The output is high from the start of each cycle for (divider + 1) * high_count input clocks and low for the rest; a high count of zero keeps it low.
- R7: When high_count is greater than or equal to cycle_count the output stays high continuously.
- R8: Clearing the global run bit (bit 0 at 0x3C) drives all outputs low from the clock after the write, and channels restart a fresh cycle when it is set again.
- R9: Clearing one channel's run bit drives only that output low from the clock after the write; the other channels keep running.
- R10: When a write makes a channel runnable, its output rises on the second clock edge after the write is presented (one clock after the write is taken), if its high count is nonzero.
- R11: Count and divider values written while a channel runs take effect only at the next cycle boundary; the cycle in progress completes with the old values.
- R12: The four channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read, qualified by req_valid |
| req_addr | input | 6 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Combinational read data for req_addr |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The assertions take for granted that reset is held from the first clock edge and that the bus inputs never carry unknown values, since the read-data and counter properties evaluate them every cycle. The bench drives every bus input to a defined level at time zero, keeps the strobe low outside its access tasks and only releases reset after several clocks. Random settings are drawn so that the high count lies strictly below the cycle count, which lets a single rise-to-rise window measure both times; the cases where the high count reaches or exceeds the cycle count, or is zero, are covered by directed steps.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int PRE_W = 14,
  parameter int DW    = 32,
  parameter int AW    = $clog2(NCH * 16)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic [NCH-1:0] pwm_out
);

  localparam int SW = AW - 4;
  localparam logic [AW-3:0] MASTER_WORD = (AW-2)'((NCH * 16 - 4) / 4);

  logic                           master_en;
  logic [NCH-1:0]                 en_r;
  logic [NCH-1:0][PRE_W-1:0]      pre_r;
  logic [NCH-1:0][CNT_W-1:0]      duty_r, per_r;

  logic [NCH-1:0]                 active;
  logic [NCH-1:0][PRE_W-1:0]      sh_pre, cnt_pre;
  logic [NCH-1:0][CNT_W-1:0]      sh_duty, sh_per, cnt_per;

  logic [NCH-1:0] run_v, pre_last, per_last;

  wire [AW-3:0] word  = req_addr[AW-1:2];
  wire [SW-1:0] sel   = req_addr[AW-1:4];
  wire [1:0]    off   = req_addr[3:2];
  wire          wr_en = req_valid & req_write;
  wire          is_master = (word == MASTER_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      en_r      <= '0;
      pre_r     <= '0;
      duty_r    <= '0;
      per_r     <= '0;
    end else if (wr_en) begin
      if (is_master) master_en <= req_wdata[0];
      else begin
        for (int i = 0; i < NCH; i++) begin
          if (sel == SW'(i)) begin
            case (off)
              2'd0: begin
                en_r[i]  <= req_wdata[0];
                pre_r[i] <= req_wdata[PRE_W+1:2];
              end
              2'd1: duty_r[i] <= req_wdata[CNT_W-1:0];
              2'd2: per_r[i]  <= req_wdata[CNT_W-1:0];
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (is_master) rsp_rdata[0] = master_en;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (sel == SW'(i)) begin
          case (off)
            2'd0: begin
              rsp_rdata[0]         = en_r[i];
              rsp_rdata[PRE_W+1:2] = pre_r[i];
            end
            2'd1: rsp_rdata[CNT_W-1:0] = duty_r[i];
            2'd2: rsp_rdata[CNT_W-1:0] = per_r[i];
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign run_v[g]    = master_en & en_r[g];
    assign pre_last[g] = (cnt_pre[g] == sh_pre[g]);
    assign per_last[g] = ({1'b0, cnt_per[g]} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, sh_per[g]};
    assign pwm_out[g]  = run_v[g] & active[g] & (cnt_per[g] < sh_duty[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= '0;
      sh_pre  <= '0;
      sh_duty <= '0;
      sh_per  <= '0;
      cnt_pre <= '0;
      cnt_per <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (!run_v[i]) begin
          active[i]  <= 1'b0;
          cnt_pre[i] <= '0;
          cnt_per[i] <= '0;
        end else if (!active[i] || (pre_last[i] && per_last[i])) begin
          active[i]  <= 1'b1;
          sh_pre[i]  <= pre_r[i];
          sh_duty[i] <= duty_r[i];
          sh_per[i]  <= per_r[i];
          cnt_pre[i] <= '0;
          cnt_per[i] <= '0;
        end else if (pre_last[i]) begin
          cnt_pre[i] <= '0;
          cnt_per[i] <= cnt_per[i] + 1'b1;
        end else begin
          cnt_pre[i] <= cnt_pre[i] + 1'b1;
        end
      end
    end
  end

endmodule

module pwm_quad_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int PRE_W = 14,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW-1:0]             req_addr,
  input logic [DW-1:0]             rsp_rdata,
  input logic                      master_en,
  input logic [NCH-1:0]            en_r,
  input logic [NCH-1:0]            active,
  input logic [NCH-1:0][PRE_W-1:0] sh_pre,
  input logic [NCH-1:0][PRE_W-1:0] cnt_pre,
  input logic [NCH-1:0][CNT_W-1:0] sh_per,
  input logic [NCH-1:0][CNT_W-1:0] cnt_per,
  input logic [NCH-1:0]            pwm_out
);

  localparam logic [AW-3:0] MASTER_WORD = (AW-2)'((NCH * 16 - 4) / 4);

  // R8
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pwm_out == '0));

  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[3:2] == 2'b11 && req_addr[AW-1:2] != MASTER_WORD) |-> (rsp_rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R9
    chan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_r[g] |-> !pwm_out[g]);

    // R5
    cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active[g] |-> ((sh_per[g] == '0) ? (cnt_per[g] == '0) : (cnt_per[g] < sh_per[g])));

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active[g] |-> (cnt_pre[g] <= sh_pre[g]));

    // R11
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active[g] && $past(active[g]) && cnt_per[g] != '0) |-> ($stable(sh_per[g]) && $stable(sh_pre[g])));
  end

endmodule

bind pwm_quad pwm_quad_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .DW(DW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .rsp_rdata(rsp_rdata),
  .master_en(master_en), .en_r(en_r), .active(active),
  .sh_pre(sh_pre), .cnt_pre(cnt_pre), .sh_per(sh_per), .cnt_per(cnt_per),
  .pwm_out(pwm_out)
);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_quad u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [5:0] adr(int ch, int reg_off);
    return 6'(ch * 16 + reg_off);
  endfunction

  function automatic logic [31:0] ctrl_word(int pre, bit en);
    return (32'(pre) << 2) | 32'(en);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic wait_rise(int ch, output bit ok);
    logic prev;
    ok = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) begin ok = 1; return; end
      prev = pwm_out[ch];
    end
  endtask

  task automatic count_rest(int ch, output int hi, output int tot);
    logic prev;
    hi = 1; tot = 1; prev = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) return;
      tot++;
      if (pwm_out[ch]) hi++;
      prev = pwm_out[ch];
    end
  endtask

  task automatic hold_level(string tag, int ch, logic lvl, int n);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch] !== lvl) bad++;
    end
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic setup(int ch, int pre, int duty, int per);
    wr(adr(ch, 0), 32'd0);
    wr(adr(ch, 4), 32'(duty));
    wr(adr(ch, 8), 32'(per));
    wr(adr(ch, 0), ctrl_word(pre, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, tot;
    bit ok;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 12; o += 4) begin
        rd(adr(c, o), d);
        chk("R1 reg zero", d, 32'd0);
      end
    rd(6'h3C, d); chk("R1 master zero", d, 32'd0);
    chk("R1 outputs low", 32'(pwm_out), 32'd0);

    // R3 field layout and readback
    wr(adr(1, 0), 32'hFFFF_FFFF);
    rd(adr(1, 0), d); chk("R3 ctrl mask", d, 32'h0000_FFFD);
    wr(adr(1, 0), 32'h0000_A5A8);
    rd(adr(1, 0), d); chk("R3 ctrl readback", d, 32'h0000_A5A8);
    wr(adr(1, 0), 32'd0);

    // R2 address map, low bits ignored
    for (int c = 0; c < 4; c++) begin
      wr(adr(c, 4), 32'(16'h1100 + c));
      wr(adr(c, 8) | 6'd3, 32'(16'h2200 + c));
    end
    for (int c = 0; c < 4; c++) begin
      rd(adr(c, 4) | 6'd2, d); chk("R2 duty map", d, 32'(16'h1100 + c));
      rd(adr(c, 8), d);        chk("R2 period map", d, 32'(16'h2200 + c));
    end

    // R4 unmapped offsets
    for (int c = 0; c < 3; c++) begin
      wr(adr(c, 12), 32'hFFFF_FFFF);
      rd(adr(c, 12), d); chk("R4 unmapped read", d, 32'd0);
      rd(adr(c, 0), d);  chk("R4 ctrl untouched", d, 32'd0);
      rd(adr(c, 4), d);  chk("R4 duty untouched", d, 32'(16'h1100 + c));
    end
    rd(6'h3C, d); chk("R4 master untouched", d, 32'd0);

    // R10 start latency
    wr(6'h3C, 32'd1);
    wr(adr(0, 4), 32'd3);
    wr(adr(0, 8), 32'd5);
    wr(adr(0, 0), ctrl_word(0, 1'b1));
    chk("R10 low right after write", 32'(pwm_out[0]), 32'd0);
    @(negedge clk);
    chk("R10 high one clock later", 32'(pwm_out[0]), 32'd1);

    // R5 R6 directed with divider
    setup(0, 2, 3, 7);
    wait_rise(0, ok); chk("R6 rise seen", 32'(ok), 32'd1);
    count_rest(0, hi, tot);
    chk("R6 high time pre2", 32'(hi), 32'd9);
    chk("R5 cycle time pre2", 32'(tot), 32'd21);

    // R7 high >= cycle
    setup(1, 1, 4, 4);
    @(negedge clk);
    hold_level("R7 equal stays high", 1, 1'b1, 30);
    setup(1, 0, 9, 4);
    @(negedge clk);
    hold_level("R7 greater stays high", 1, 1'b1, 30);

    // R6 zero high count
    setup(3, 0, 0, 5);
    hold_level("R6 zero high stays low", 3, 1'b0, 30);

    // R5 zero cycle count acts as one
    setup(3, 3, 1, 0);
    @(negedge clk);
    hold_level("R5 zero cycle count", 3, 1'b1, 30);

    // R9 single channel disable
    wr(adr(3, 0), 32'd0);
    chk("R9 disabled channel low", 32'(pwm_out[3]), 32'd0);
    chk("R9 other channel running", 32'(pwm_out[1]), 32'd1);

    // R8 global disable and restart
    wr(6'h3C, 32'd0);
    chk("R8 all low after global clear", 32'(pwm_out), 32'd0);
    hold_level("R8 stays low", 1, 1'b0, 10);
    wr(6'h3C, 32'd1);
    @(negedge clk);
    chk("R8 restart", 32'(pwm_out[1]), 32'd1);

    // R11 mid-cycle update
    setup(2, 0, 5, 10);
    wait_rise(2, ok);
    fork
      count_rest(2, hi, tot);
      begin
        wr(adr(2, 4), 32'd2);
        wr(adr(2, 8), 32'd4);
      end
    join
    chk("R11 old high kept", 32'(hi), 32'd5);
    chk("R11 old cycle kept", 32'(tot), 32'd10);
    count_rest(2, hi, tot);
    chk("R11 new high applied", 32'(hi), 32'd2);
    chk("R11 new cycle applied", 32'(tot), 32'd4);

    // R12 random settings across channels
    for (int it = 0; it < 16; it++) begin
      int ch, pre, per, duty;
      ch   = int'($urandom % 4);
      pre  = int'($urandom % 4);
      per  = 2 + int'($urandom % 19);
      duty = 1 + int'($urandom % (per - 1));
      setup(ch, pre, duty, per);
      wait_rise(ch, ok);
      count_rest(ch, hi, tot);
      chk("R12 random high", 32'(hi), 32'((pre + 1) * duty));
      chk("R12 random cycle", 32'(tot), 32'((pre + 1) * per));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule